// File: doc/BRIEF.md
# Stallable Point-to-Point Data Channel with Selectable Clock Crossing

This block carries a wide packed record from a producer to a consumer. The producer raises `in_valid` with a word on `in_data`. The word is taken on any producer clock edge where `in_busy` is low. On the far side the channel raises `out_valid` with the oldest word on `out_data`. The consumer holds `out_busy` high to stall, and the word is taken on any consumer clock edge where `out_busy` is low. The record is one flat vector whose width is a parameter. Packing and unpacking the fields belongs to the logic around the channel.

A build-time parameter, `MODE`, chooses how the channel is built. The port list and the handshake rules are the same for every choice, so a clock crossing can be added or removed late in a design without touching the surrounding code:

- Mode 0 is a single register stage on the producer clock. In this mode the consumer clock and the consumer reset are not used.
- Mode 1 is a register-only crossing. It uses a toggle request/acknowledge pair and holds one word. It is intended for crossings from a slow clock to a fast one.
- Mode 2 is a dual-clock FIFO of 2^`DEPTH_LOG2` words. It is built on a two-port storage array and passes Gray-coded pointers between the domains.

Instances chain directly: the outputs of one drive the inputs of the next, and the busy of the next drives the busy of the previous. This forms a stallable pipeline.

Top module: `xfer_channel`

## Requirements
- R1: After the producer and consumer resets are released, `out_valid` is low and `in_busy` is low. Any words that were held before the reset are discarded.
- R2: In mode 0, a word accepted on one edge is presented on `out_valid` after that same edge. With the consumer never busy and the producer always valid, one word passes on every clock.
- R3: While `out_valid` is high and `out_busy` is high, `out_valid` stays high and `out_data` does not change on the next consumer edge.
- R4: In every mode and under any valid/busy pattern, each accepted word is delivered exactly once and in order of acceptance.
- R5: In mode 1, `in_busy` rises on the producer edge after a word is accepted. It stays high until the consumer has taken the word and the acknowledge has returned, so the channel holds exactly one word.
- R6: In mode 2, with the consumer busy from an empty state, the channel accepts exactly 2^`DEPTH_LOG2` words and then holds `in_busy` high.
- R7: `out_valid` is high only while a word is held. Once every accepted word has been taken, `out_valid` is low, and `in_busy` is low after the crossing latency.
- R8: Two mode-0 instances chained output to input form a two-word pipeline. It has a latency of two clocks from acceptance to first presentation, and it accepts exactly two words while the consumer stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| prod_clk | input | 1 | Producer clock (the only clock in mode 0) |
| prod_rst_n | input | 1 | Producer-domain asynchronous reset, active low |
| in_valid | input | 1 | Producer presents a word |
| in_data | input | DATA_W | Packed record from the producer |
| in_busy | output | 1 | Channel cannot take a word this producer edge |
| cons_clk | input | 1 | Consumer clock (not used in mode 0) |
| cons_rst_n | input | 1 | Consumer-domain asynchronous reset, active low (not used in mode 0) |
| out_valid | output | 1 | A word is available to the consumer |
| out_data | output | DATA_W | Oldest held word |
| out_busy | input | 1 | Consumer stalls the channel |

## Verification
Some properties are checked on every cycle by assertions:
- A stalled output word stays valid and unchanged.
- A mode-0 stage presents a word on the edge after it takes one, and empties when drained with no new input.
- The register crossing raises busy after each accepted word and never presents a word twice.
- The FIFO fill level seen on the write side never exceeds its depth.

Other behaviours only show up in the bench scenarios, because they need whole streams or counts:
- Ordering and exact delivery under random valid and busy patterns in all three modes.
- The per-mode stall capacity of one, two and 2^`DEPTH_LOG2` words.
- Back-to-back throughput and the two-clock latency of a chained pair.
- Emptiness after draining and after a reset that flushes held words.

// File: rtl/xc_pkg.sv
// Shared constants and pointer arithmetic for the data channel.
package xc_pkg;

  // Implementation choices for the MODE parameter.
  localparam int XC_SAME_CLK = 0;
  localparam int XC_CDC_REG  = 1;
  localparam int XC_CDC_FIFO = 2;

  // Binary to reflected Gray code.
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Reflected Gray code back to binary.
  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // Distance between two wrapping pointers; the caller truncates to pointer width.
  function automatic logic [31:0] ptr_gap(input logic [31:0] ahead, input logic [31:0] behind);
    return ahead - behind;
  endfunction

endpackage

// File: rtl/xc_sync2.sv
// Two-flop synchronizer for a vector that changes at most one bit at a time.
module xc_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/xc_reg_stage.sv
// Same-clock variant: one register slot that can be refilled in the cycle it empties.
module xc_reg_stage #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_busy,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_busy
);

  logic         full_q;
  logic [W-1:0] data_q;
  logic         load;   // a word enters the slot this edge
  logic         drain;  // the held word leaves this edge

  // The slot refuses a word only when it is occupied and cannot empty.
  assign in_busy   = full_q & out_busy;
  assign load      = in_valid & ~in_busy;
  assign drain     = full_q & ~out_busy;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (load) begin
        data_q <= in_data;
        full_q <= 1'b1;
      end else if (drain) begin
        full_q <= 1'b0;
      end
    end
  end

  // R2: an accepted word is presented after the same edge
  assert_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_busy) |=> out_valid);

  // R3: a stalled word stays put
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_busy) |=> (out_valid && $stable(out_data)));

  // R7: draining with nothing arriving leaves the stage empty
  assert_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_busy && !in_valid) |=> !out_valid);

endmodule

// File: rtl/xc_cdc_hs.sv
// Register-only crossing: toggle request out, toggle acknowledge back, one word held.
module xc_cdc_hs #(
  parameter int W = 64
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_busy,
  input  logic         rclk,
  input  logic         rrst_n,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_busy
);

  // Producer domain
  logic         req_t;    // flips once per accepted word
  logic [W-1:0] hold_q;   // frozen from request until acknowledge
  logic         ack_w;    // acknowledge toggle seen in producer domain
  logic         pending;  // word in flight
  logic         put;

  // Consumer domain
  logic         req_r;    // request toggle seen in consumer domain
  logic         seen_t;   // last request toggle taken by the consumer
  logic         take;

  assign pending = req_t ^ ack_w;
  assign in_busy = pending;
  assign put     = in_valid & ~pending;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      req_t  <= 1'b0;
      hold_q <= '0;
    end else if (put) begin
      req_t  <= ~req_t;
      hold_q <= in_data;
    end
  end

  xc_sync2 #(.W(1)) u_req_sync (
    .clk   (rclk),
    .rst_n (rrst_n),
    .d     (req_t),
    .q     (req_r)
  );

  assign out_valid = req_r ^ seen_t;
  assign out_data  = hold_q;
  assign take      = out_valid & ~out_busy;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      seen_t <= 1'b0;
    end else if (take) begin
      seen_t <= req_r;
    end
  end

  xc_sync2 #(.W(1)) u_ack_sync (
    .clk   (wclk),
    .rst_n (wrst_n),
    .d     (seen_t),
    .q     (ack_w)
  );

  // R5: accepting a word closes the channel until the acknowledge returns
  assert_busy_after_put_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
    put |=> in_busy);

  // R3: the presented word is held while the consumer stalls
  assert_hold_R3: assert property (@(posedge rclk) disable iff (!rrst_n)
    (out_valid && out_busy) |=> (out_valid && $stable(out_data)));

  // R4: a taken word is not presented again on the next edge
  assert_no_dup_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
    take |=> !out_valid);

endmodule

// File: rtl/xc_cdc_fifo.sv
// Dual-clock FIFO on a two-port array; Gray pointers cross through two-flop synchronizers.
module xc_cdc_fifo #(
  parameter int W  = 64,
  parameter int AW = 3
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_busy,
  input  logic         rclk,
  input  logic         rrst_n,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_busy
);

  import xc_pkg::*;

  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;   // one wrap bit above the address

  logic [W-1:0]  mem [DEPTH];

  // Write domain
  logic [PW-1:0] wbin, wbin_nx, wgray, rgray_w, wr_level;
  logic          full, wr_fire;

  // Read domain
  logic [PW-1:0] rbin, rbin_nx, rgray, wgray_r;
  logic          empty, rd_fire;

  // Fill level as seen by the writer (may over-count, never under-count)
  assign wr_level = PW'(ptr_gap(32'(wbin), from_gray(32'(rgray_w))));
  assign full     = (wr_level == PW'(DEPTH));
  assign in_busy  = full;
  assign wr_fire  = in_valid & ~full;
  assign wbin_nx  = wbin + 1'b1;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_fire) begin
      wbin  <= wbin_nx;
      wgray <= PW'(to_gray(32'(wbin_nx)));
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_fire) begin
      mem[wbin[AW-1:0]] <= in_data;
    end
  end

  xc_sync2 #(.W(PW)) u_rptr_sync (
    .clk   (wclk),
    .rst_n (wrst_n),
    .d     (rgray),
    .q     (rgray_w)
  );

  xc_sync2 #(.W(PW)) u_wptr_sync (
    .clk   (rclk),
    .rst_n (rrst_n),
    .d     (wgray),
    .q     (wgray_r)
  );

  assign empty     = (rgray == wgray_r);
  assign out_valid = ~empty;
  assign out_data  = mem[rbin[AW-1:0]];
  assign rd_fire   = out_valid & ~out_busy;
  assign rbin_nx   = rbin + 1'b1;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_fire) begin
      rbin  <= rbin_nx;
      rgray <= PW'(to_gray(32'(rbin_nx)));
    end
  end

  // R6: the writer never holds more than DEPTH unread words
  assert_no_overflow_R6: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_level <= PW'(DEPTH));

  // R3: the head word is held while the consumer stalls
  assert_hold_R3: assert property (@(posedge rclk) disable iff (!rrst_n)
    (out_valid && out_busy) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/xfer_channel.sv
// Point-to-point stallable channel; MODE picks the implementation behind fixed ports.
module xfer_channel #(
  parameter int DATA_W     = 64,
  parameter int MODE       = 2,   // 0 same clock, 1 register crossing, 2 FIFO crossing
  parameter int DEPTH_LOG2 = 3
) (
  input  logic              prod_clk,
  input  logic              prod_rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_busy,
  input  logic              cons_clk,
  input  logic              cons_rst_n,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_busy
);

  import xc_pkg::*;

  generate
    if (MODE == XC_SAME_CLK) begin : g_same
      // Consumer clock and reset are not used by the single-clock stage.
      logic unused_cons;
      assign unused_cons = cons_clk ^ cons_rst_n;

      xc_reg_stage #(.W(DATA_W)) u_stage (
        .clk       (prod_clk),
        .rst_n     (prod_rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_busy   (in_busy),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_busy  (out_busy)
      );
    end else if (MODE == XC_CDC_REG) begin : g_hs
      xc_cdc_hs #(.W(DATA_W)) u_hs (
        .wclk      (prod_clk),
        .wrst_n    (prod_rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_busy   (in_busy),
        .rclk      (cons_clk),
        .rrst_n    (cons_rst_n),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_busy  (out_busy)
      );
    end else begin : g_fifo
      xc_cdc_fifo #(.W(DATA_W), .AW(DEPTH_LOG2)) u_fifo (
        .wclk      (prod_clk),
        .wrst_n    (prod_rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_busy   (in_busy),
        .rclk      (cons_clk),
        .rrst_n    (cons_rst_n),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_busy  (out_busy)
      );
    end
  endgenerate

endmodule

// File: tb/xfer_channel_tb.sv
`timescale 1ns/1ps
// Lanes: 0 = two same-clock stages chained, 1 = register crossing, 2 = FIFO crossing (u_dut).
module xfer_channel_tb;
  import xc_pkg::*;

  localparam int W     = 40;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, cclk = 1'b0;
  logic prst_n = 1'b0, crst_n = 1'b0;
  always #4   clk  = ~clk;    // 125 MHz producer clock
  always #2.5 cclk = ~cclk;   // faster consumer clock

  logic [2:0]        iv, ib, ov, ob;
  logic [2:0][W-1:0] id, od;
  logic              m_v, m_b;
  logic [W-1:0]      m_d;

  int checks = 0, errors = 0;
  int pcyc = 0;
  always @(posedge clk) pcyc <= pcyc + 1;

  xfer_channel #(.DATA_W(W), .MODE(XC_SAME_CLK), .DEPTH_LOG2(AW)) u_dut_rega (
    .prod_clk(clk), .prod_rst_n(prst_n), .in_valid(iv[0]), .in_data(id[0]), .in_busy(ib[0]),
    .cons_clk(clk), .cons_rst_n(crst_n), .out_valid(m_v), .out_data(m_d), .out_busy(m_b));

  xfer_channel #(.DATA_W(W), .MODE(XC_SAME_CLK), .DEPTH_LOG2(AW)) u_dut_regb (
    .prod_clk(clk), .prod_rst_n(prst_n), .in_valid(m_v), .in_data(m_d), .in_busy(m_b),
    .cons_clk(clk), .cons_rst_n(crst_n), .out_valid(ov[0]), .out_data(od[0]), .out_busy(ob[0]));

  xfer_channel #(.DATA_W(W), .MODE(XC_CDC_REG), .DEPTH_LOG2(AW)) u_dut_hs (
    .prod_clk(clk), .prod_rst_n(prst_n), .in_valid(iv[1]), .in_data(id[1]), .in_busy(ib[1]),
    .cons_clk(cclk), .cons_rst_n(crst_n), .out_valid(ov[1]), .out_data(od[1]), .out_busy(ob[1]));

  xfer_channel #(.DATA_W(W), .MODE(XC_CDC_FIFO), .DEPTH_LOG2(AW)) u_dut (
    .prod_clk(clk), .prod_rst_n(prst_n), .in_valid(iv[2]), .in_data(id[2]), .in_busy(ib[2]),
    .cons_clk(cclk), .cons_rst_n(crst_n), .out_valid(ov[2]), .out_data(od[2]), .out_busy(ob[2]));

  // Shared state of the one scenario running at a time
  bit hold;
  int acc_hold, p_first, c_first, c_last;

  function automatic logic [W-1:0] gen(input int l, input int k);
    return {8'(l + 1), 32'(k) * 32'h9E37_79B1};
  endfunction

  // Words a lane can absorb while its consumer stalls
  function automatic int cap(input int l);
    if (l == 0) return 2;   // R8
    if (l == 1) return 1;   // R5
    return DEPTH;           // R6
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cons_edge(input int l);
    if (l == 0) @(negedge clk);
    else        @(negedge cclk);
  endtask

  task automatic producer(input int l, input int n, input int vmode);
    int k = 0;
    int guard = 0;
    bit acc = 0;
    logic [15:0] lf = 16'hACE1 ^ 16'(l * 77);
    p_first = -1;
    while (k < n && guard < 20000) begin
      @(negedge clk); #1;
      guard++;
      if (acc) begin
        k++;
        iv[l] = 1'b0;
      end
      acc = 0;
      if (k < n) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (!iv[l]) iv[l] = (vmode == 0) || lf[0] || lf[5];
        id[l] = gen(l, k);
        #1;
        if (iv[l] && !ib[l]) begin
          acc = 1;
          if (p_first < 0) p_first = pcyc;
          if (hold) acc_hold++;
        end
      end
    end
    iv[l] = 1'b0;
  endtask

  task automatic consumer(input int l, input int n, input int bmode, input int hold_cyc);
    int got = 0;
    int cc = 0;
    logic [15:0] lf = 16'h1D2B ^ 16'(l * 31);
    c_first = -1;
    c_last  = -1;
    hold = (hold_cyc > 0);
    while (got < n && cc < 40000) begin
      cons_edge(l);
      cc++;
      if (hold && cc > hold_cyc) begin
        hold = 0;
        chk(ov[l] == 1'b1, "R3", "valid held through stall", ov[l], 1);
        chk(od[l] == gen(l, 0), "R3", "head word held through stall", od[l], gen(l, 0));
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ob[l] = hold || (bmode == 1 && (lf[0] || lf[7]));
      #1;
      if (ov[l] && !ob[l]) begin
        chk(od[l] == gen(l, got), "R4", $sformatf("lane %0d word %0d", l, got), od[l], gen(l, got));
        if (c_first < 0) c_first = pcyc;
        c_last = pcyc;
        got++;
      end
    end
    ob[l] = 1'b0;
    chk(got == n, "R4", $sformatf("lane %0d words delivered", l), got, n);
  endtask

  task automatic run(input int l, input int n, input int vmode, input int bmode, input int hold_cyc);
    acc_hold = 0;
    fork
      producer(l, n, vmode);
      consumer(l, n, bmode, hold_cyc);
    join
  endtask

  task automatic check_idle(input int l);
    repeat (12) @(negedge clk);
    chk(ov[l] == 1'b0, "R7", $sformatf("lane %0d valid low when empty", l), ov[l], 0);
    chk(ib[l] == 1'b0, "R7", $sformatf("lane %0d busy low when empty", l), ib[l], 0);
  endtask

  // R1: nothing held after reset
  task automatic t_reset_state();
    for (int l = 0; l < 3; l++) begin
      chk(ov[l] == 1'b0, "R1", $sformatf("lane %0d valid after reset", l), ov[l], 0);
      chk(ib[l] == 1'b0, "R1", $sformatf("lane %0d busy after reset", l), ib[l], 0);
    end
  endtask

  // R2/R4/R8: free-flowing stream
  task automatic t_stream(input int l);
    run(l, 32, 0, 0, 0);
    if (l == 0) begin
      chk(c_last - c_first == 31, "R2", "one word per clock", c_last - c_first, 31);
      chk(c_first - p_first == 2, "R8", "chained latency", c_first - p_first, 2);
    end
    check_idle(l);
  endtask

  // R3/R5/R6/R8: consumer stalls from empty, then releases
  task automatic t_stall(input int l);
    string tag;
    run(l, 16, 0, 0, 40);
    tag = (l == 0) ? "R8" : ((l == 1) ? "R5" : "R6");
    chk(acc_hold == cap(l), tag, $sformatf("lane %0d words taken while stalled", l), acc_hold, cap(l));
    check_idle(l);
  endtask

  // R4: random valid gaps and random busy
  task automatic t_random(input int l);
    run(l, 60, 1, 1, 0);
    check_idle(l);
  endtask

  // R1: a reset discards held words
  task automatic t_reset_flush();
    ob = 3'b111;
    for (int l = 0; l < 3; l++) id[l] = gen(l, 99);
    iv = 3'b111;
    repeat (20) @(negedge clk);
    prst_n = 1'b0;
    crst_n = 1'b0;
    iv = 3'b000;
    repeat (3) @(negedge clk);
    prst_n = 1'b1;
    crst_n = 1'b1;
    ob = 3'b000;
    repeat (3) @(negedge clk);
    for (int l = 0; l < 3; l++) begin
      chk(ov[l] == 1'b0, "R1", $sformatf("lane %0d valid after flush", l), ov[l], 0);
      chk(ib[l] == 1'b0, "R1", $sformatf("lane %0d busy after flush", l), ib[l], 0);
    end
    run(2, 10, 0, 0, 0);
  endtask

  initial begin
    iv = '0;
    ob = '0;
    id = '0;
    repeat (4) @(negedge clk);
    crst_n = 1'b1;
    @(negedge clk);
    prst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    for (int l = 0; l < 3; l++) t_stream(l);
    for (int l = 0; l < 3; l++) t_stall(l);
    for (int l = 0; l < 3; l++) t_random(l);
    t_reset_flush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule